// File: doc/BRIEF.md
# Interrupt State Register Bank

This block keeps the per-interrupt state of a small interrupt distributor: an enable bit, a pending bit, an active bit, a priority and a trigger mode for each interrupt. It presents that state as memory-mapped registers. Enable, pending and active each appear as a pair of registers. One register of the pair sets bits and the other clears them, and both read back the current state. Priority takes one byte per interrupt. Trigger mode takes a two-bit field per interrupt.

An upstream bus decoder gives the block a register group, a word index, an access size with a byte lane, a write strobe and write data. Reads are combinational from the same selection. Each interrupt's input line level comes in as its own wire, and the registered pending vector goes out to a downstream arbiter. Level-triggered interrupts keep a software-pending latch next to the live line. Writes that clear pending, or that switch an interrupt to level mode, rebuild pending from that latch and the line. The lowest-numbered interrupts are private and always level-triggered.

Top module: `irq_state_bank`

## Requirements
- R1: After reset every interrupt is disabled, not active, not pending (with lines low), level-triggered and at priority zero, so all register reads return zero.
- R2: The register group is selected by `regSel`: 0 enable-set, 1 enable-clear, 2 pending-set, 3 pending-clear, 4 active-set, 5 active-clear, 6 priority, 7 trigger mode. In groups 0-5, word w bit b is interrupt 32w+b. A read of either register of a pair returns the current state. Writing a 1 sets the bit (set register) or clears it (clear register), and a 0 bit leaves it unchanged.
- R3: Writing 1 to pending-set makes that interrupt pending. For a level-triggered interrupt it also sets the software-pending latch.
- R4: Writing 1 to pending-clear on a level-triggered interrupt clears its latch and sets pending to the current line level. On an edge-triggered interrupt it clears pending and leaves the latch alone.
- R5: For a level-triggered interrupt, pending at each clock edge becomes the line level OR the software-pending latch.
- R6: An edge-triggered interrupt becomes pending on a low-to-high transition of its line. It stays pending after the line falls and stays clear while the line is held high.
- R7: Priority word w byte k belongs to interrupt 4w+k. Only the upper 5 bits of each byte are stored, and the low 3 bits read as zero.
- R8: Trigger word w holds interrupts 16w..16w+15, two bits each at bits 2k+1:2k. Bit 2k+1 is 1 for edge and 0 for level, and bit 2k always reads zero.
- R9: Trigger-mode writes to interrupts 0-31 (the private ones) are ignored, and those interrupts read as level-triggered.
- R10: When an interrupt is switched to level mode, its pending bit becomes the line level OR its software-pending latch. This includes a latch left over from earlier level operation.
- R11: A byte access (`byteAcc`=1) writes only the lane `byteLane`, taking the data from `wrData[7:0]`, and reads that lane zero-extended. A word index beyond the group's size (2 words for bit groups, 16 for priority, 4 for trigger) reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 3 | Register group select (see R2) |
| wordIdx | input | 4 | Word index within the group |
| byteAcc | input | 1 | 1 = byte access, 0 = 32-bit access |
| byteLane | input | 2 | Byte lane for a byte access |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| lineLevel | input | 64 | Live input line level of each interrupt |
| rdData | output | 32 | Combinational read data |
| pendingOut | output | 64 | Registered pending vector |

## Verification
The bench targets the places where level and edge pending rules meet. One case clears pending while a level line is still high; a design that zeroes pending there loses a live interrupt. Another switches to level mode with only a stale software latch set; a design that ignores the latch drops a software-raised request. A third holds an edge line high across a clear; a design that treats edge interrupts as levels raises a false re-trigger. It also writes trigger bits for private interrupts, writes byte lanes with junk in the upper data bits, and uses word indices past the end of a group. A design that broke any of these would let private interrupts turn edge-triggered, corrupt neighbouring lanes, or alias beyond its range.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

  localparam int DATA_W      = 32;
  localparam int IDX_FIELD_W = 8;

  typedef enum logic [2:0] {
    GRP_EN_SET = 3'd0,
    GRP_EN_CLR = 3'd1,
    GRP_PD_SET = 3'd2,
    GRP_PD_CLR = 3'd3,
    GRP_AC_SET = 3'd4,
    GRP_AC_CLR = 3'd5,
    GRP_PRIO   = 3'd6,
    GRP_CFG    = 3'd7
  } regGrp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                   enSet;
    logic                   enClr;
    logic                   pdSet;
    logic                   pdClr;
    logic                   acSet;
    logic                   acClr;
    logic                   prioWr;
    logic                   cfgWr;
    regGrp_t                grp;
    logic                   hit;
    logic [IDX_FIELD_W-1:0] idx;
    logic [3:0]             laneMask;
    logic [DATA_W-1:0]      data;
  } bankCtrl_t;

endpackage

// File: rtl/irqbank_ctrl.sv
module irqbank_ctrl
  import irqbank_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int IDX_W   = 4
) (
  input  logic [2:0]        regSel,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic              byteAcc,
  input  logic [1:0]        byteLane,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rdWord,
  output bankCtrl_t         ctrl,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [IDX_FIELD_W:0] BIT_WORDS  = (IDX_FIELD_W+1)'(NUM_IRQ / 32);
  localparam logic [IDX_FIELD_W:0] PRIO_WORDS = (IDX_FIELD_W+1)'(NUM_IRQ / 4);
  localparam logic [IDX_FIELD_W:0] CFG_WORDS  = (IDX_FIELD_W+1)'(NUM_IRQ / 16);

  regGrp_t                grp;
  logic [IDX_FIELD_W-1:0] idxExt;
  logic [IDX_FIELD_W:0]   limit;
  logic                   inRange;
  logic                   doWr;

  always_comb begin
    grp    = regGrp_t'(regSel);
    idxExt = IDX_FIELD_W'(wordIdx);
    case (grp)
      GRP_PRIO: limit = PRIO_WORDS;
      GRP_CFG:  limit = CFG_WORDS;
      default:  limit = BIT_WORDS;
    endcase
    inRange = {1'b0, idxExt} < limit;
    doWr    = wrEn & inRange;

    ctrl.grp      = grp;
    ctrl.hit      = inRange;
    ctrl.idx      = idxExt;
    ctrl.laneMask = byteAcc ? (4'b0001 << byteLane) : 4'b1111;
    ctrl.data     = byteAcc ? {4{wrData[7:0]}} : wrData;
    ctrl.enSet    = doWr & (grp == GRP_EN_SET);
    ctrl.enClr    = doWr & (grp == GRP_EN_CLR);
    ctrl.pdSet    = doWr & (grp == GRP_PD_SET);
    ctrl.pdClr    = doWr & (grp == GRP_PD_CLR);
    ctrl.acSet    = doWr & (grp == GRP_AC_SET);
    ctrl.acClr    = doWr & (grp == GRP_AC_CLR);
    ctrl.prioWr   = doWr & (grp == GRP_PRIO);
    ctrl.cfgWr    = doWr & (grp == GRP_CFG);

    rdData = byteAcc ? {24'b0, rdWord[8*byteLane +: 8]} : rdWord;
  end

endmodule

// File: rtl/irqbank_regs.sv
module irqbank_regs
  import irqbank_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_PRIV  = 32,
  parameter int PRIO_BITS = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  bankCtrl_t          ctrl,
  input  logic [NUM_IRQ-1:0] lineLevel,
  output logic [DATA_W-1:0]  rdWord,
  output logic [NUM_IRQ-1:0] pendingOut
);

  localparam int BIT_WORDS  = NUM_IRQ / 32;
  localparam int PRIO_WORDS = NUM_IRQ / 4;
  localparam int CFG_WORDS  = NUM_IRQ / 16;

  logic [NUM_IRQ-1:0] enQ, enNext, acQ, acNext, pdQ, pdNext;
  logic [NUM_IRQ-1:0] softQ, softNext, edgeQ, edgeNext, lineQ;
  logic [PRIO_BITS-1:0] prioQ    [NUM_IRQ];
  logic [PRIO_BITS-1:0] prioNext [NUM_IRQ];
  logic [NUM_IRQ*8-1:0] prioFlat;
  logic [NUM_IRQ*2-1:0] cfgFlat;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    localparam int BW = i / 32;
    localparam int BB = i % 32;
    localparam int PW = i / 4;
    localparam int PL = i % 4;
    localparam int CW = i / 16;
    localparam int CP = i % 16;

    logic bitSel, pSet, pClr, rise;

    assign bitSel = (ctrl.idx == IDX_FIELD_W'(BW)) && ctrl.data[BB] && ctrl.laneMask[BB/8];
    assign pSet   = ctrl.pdSet & bitSel;
    assign pClr   = ctrl.pdClr & bitSel;
    assign rise   = lineLevel[i] & ~lineQ[i];

    assign enNext[i] = (enQ[i] | (ctrl.enSet & bitSel)) & ~(ctrl.enClr & bitSel);
    assign acNext[i] = (acQ[i] | (ctrl.acSet & bitSel)) & ~(ctrl.acClr & bitSel);

    if (i < NUM_PRIV) begin : g_priv
      assign edgeNext[i] = 1'b0;
    end else begin : g_shared
      assign edgeNext[i] = (ctrl.cfgWr && ctrl.idx == IDX_FIELD_W'(CW) && ctrl.laneMask[CP/4])
                           ? ctrl.data[2*CP+1] : edgeQ[i];
    end

    // latch only moves under level rules
    assign softNext[i] = edgeNext[i] ? softQ[i]
                       : (pSet ? 1'b1 : (pClr ? 1'b0 : softQ[i]));
    assign pdNext[i]   = edgeNext[i] ? ((pdQ[i] & ~pClr) | rise | pSet)
                       : (lineLevel[i] | softNext[i]);

    assign prioNext[i] = (ctrl.prioWr && ctrl.idx == IDX_FIELD_W'(PW) && ctrl.laneMask[PL])
                         ? ctrl.data[8*PL+7 -: PRIO_BITS] : prioQ[i];

    assign prioFlat[8*i +: 8] = 8'(prioQ[i]) << (8 - PRIO_BITS);
    assign cfgFlat[2*i +: 2]  = {edgeQ[i], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      acQ   <= '0;
      pdQ   <= '0;
      softQ <= '0;
      edgeQ <= '0;
      lineQ <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prioQ[i] <= '0;
    end else begin
      enQ   <= enNext;
      acQ   <= acNext;
      pdQ   <= pdNext;
      softQ <= softNext;
      edgeQ <= edgeNext;
      lineQ <= lineLevel;
      for (int i = 0; i < NUM_IRQ; i++) prioQ[i] <= prioNext[i];
    end
  end

  always_comb begin
    rdWord = '0;
    if (ctrl.hit) begin
      case (ctrl.grp)
        GRP_EN_SET, GRP_EN_CLR:
          for (int w = 0; w < BIT_WORDS; w++)
            if (ctrl.idx == IDX_FIELD_W'(w)) rdWord = enQ[32*w +: 32];
        GRP_PD_SET, GRP_PD_CLR:
          for (int w = 0; w < BIT_WORDS; w++)
            if (ctrl.idx == IDX_FIELD_W'(w)) rdWord = pdQ[32*w +: 32];
        GRP_AC_SET, GRP_AC_CLR:
          for (int w = 0; w < BIT_WORDS; w++)
            if (ctrl.idx == IDX_FIELD_W'(w)) rdWord = acQ[32*w +: 32];
        GRP_PRIO:
          for (int w = 0; w < PRIO_WORDS; w++)
            if (ctrl.idx == IDX_FIELD_W'(w)) rdWord = prioFlat[32*w +: 32];
        GRP_CFG:
          for (int w = 0; w < CFG_WORDS; w++)
            if (ctrl.idx == IDX_FIELD_W'(w)) rdWord = cfgFlat[32*w +: 32];
        default: rdWord = '0;
      endcase
    end
  end

  assign pendingOut = pdQ;

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irqbank_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_PRIV  = 32,
  parameter int PRIO_BITS = 5,
  localparam int IDX_W    = $clog2(NUM_IRQ / 4)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regSel,
  input  logic [IDX_W-1:0]   wordIdx,
  input  logic               byteAcc,
  input  logic [1:0]         byteLane,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  input  logic [NUM_IRQ-1:0] lineLevel,
  output logic [31:0]        rdData,
  output logic [NUM_IRQ-1:0] pendingOut
);

  bankCtrl_t          ctrl;
  logic [DATA_W-1:0]  rdWord;

  irqbank_ctrl #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_ctrl (
    .regSel(regSel), .wordIdx(wordIdx), .byteAcc(byteAcc), .byteLane(byteLane),
    .wrEn(wrEn), .wrData(wrData), .rdWord(rdWord), .ctrl(ctrl), .rdData(rdData)
  );

  irqbank_regs #(.NUM_IRQ(NUM_IRQ), .NUM_PRIV(NUM_PRIV), .PRIO_BITS(PRIO_BITS)) u_regs (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .lineLevel(lineLevel),
    .rdWord(rdWord), .pendingOut(pendingOut)
  );

endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk #(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_PRIV  = 32,
  parameter int PRIO_BITS = 5,
  parameter int IDX_W     = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         regSel,
  input logic [IDX_W-1:0]   wordIdx,
  input logic               byteAcc,
  input logic               wrEn,
  input logic [31:0]        wrData,
  input logic [NUM_IRQ-1:0] lineLevel,
  input logic [31:0]        rdData,
  input logic [NUM_IRQ-1:0] pendingOut
);

  localparam int          PRIV_CFG_WORDS = NUM_PRIV / 16;
  localparam logic [7:0]  LOW_BYTE       = 8'((1 << (8 - PRIO_BITS)) - 1);
  localparam logic [31:0] PRIO_LOW_MASK  = {4{LOW_BYTE}};

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R9
  a_r9_private_cfg_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 3'd7 && !byteAcc && int'(wordIdx) < PRIV_CFG_WORDS) |-> rdData == 32'h0);

  // R8
  a_r8_cfg_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 3'd7) |-> (rdData & 32'h5555_5555) == 32'h0);

  // R7
  a_r7_prio_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 3'd6) |-> (rdData & PRIO_LOW_MASK) == 32'h0);

  // R3
  a_r3_set_pend: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 3'd2 && !byteAcc && wordIdx == '0)
    |=> (pendingOut[31:0] & $past(wrData)) == $past(wrData));

  // R4 (interrupts 0-31 are always level)
  a_r4_clr_pend_private: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 3'd3 && !byteAcc && wordIdx == '0)
    |=> (pendingOut[31:0] & $past(wrData)) == ($past(lineLevel[31:0]) & $past(wrData)));

  // R5
  a_r5_level_tracks_line: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (pendingOut[31:0] & $past(lineLevel[31:0])) == $past(lineLevel[31:0]));

endmodule

bind irq_state_bank irqbank_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_PRIV(NUM_PRIV), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wordIdx(wordIdx), .byteAcc(byteAcc),
  .wrEn(wrEn), .wrData(wrData), .lineLevel(lineLevel), .rdData(rdData),
  .pendingOut(pendingOut)
);

// File: tb/sim_irq_state_bank.sv
`timescale 1ns/1ps
module sim_irq_state_bank;

  localparam logic [2:0] EN_SET = 3'd0, EN_CLR = 3'd1, PD_SET = 3'd2, PD_CLR = 3'd3;
  localparam logic [2:0] AC_SET = 3'd4, AC_CLR = 3'd5, PRIO = 3'd6, CFG = 3'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regSel = '0;
  logic [3:0]  wordIdx = '0;
  logic        byteAcc = 1'b0;
  logic [1:0]  byteLane = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [63:0] lineLevel = '0;
  logic [31:0] rdData;
  logic [63:0] pendingOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_state_bank u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wordIdx(wordIdx), .byteAcc(byteAcc),
    .byteLane(byteLane), .wrEn(wrEn), .wrData(wrData), .lineLevel(lineLevel),
    .rdData(rdData), .pendingOut(pendingOut)
  );

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] sel, input int idx, input logic bAcc,
                    input logic [1:0] lane, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; wordIdx = idx[3:0]; byteAcc = bAcc; byteLane = lane;
    wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; byteAcc = 1'b0; byteLane = '0;
    #1;
  endtask

  task automatic rd(input logic [2:0] sel, input int idx, input logic bAcc,
                    input logic [1:0] lane, output logic [31:0] v);
    regSel = sel; wordIdx = idx[3:0]; byteAcc = bAcc; byteLane = lane;
    #1;
    v = rdData;
    byteAcc = 1'b0;
  endtask

  task automatic chkRd(input string req, input string what, input logic [2:0] sel,
                       input int idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(sel, idx, 1'b0, 2'd0, v);
    check(req, what, {32'b0, v}, {32'b0, exp});
  endtask

  task automatic testReset;
    step(1);
    chkRd("R1", "enable w0", EN_SET, 0, 32'h0);
    chkRd("R1", "enable w1", EN_CLR, 1, 32'h0);
    chkRd("R1", "active w1", AC_SET, 1, 32'h0);
    chkRd("R1", "pending w0", PD_SET, 0, 32'h0);
    chkRd("R1", "prio w15", PRIO, 15, 32'h0);
    chkRd("R1", "cfg w3", CFG, 3, 32'h0);
    check("R1", "pendingOut", pendingOut, 64'h0);
  endtask

  task automatic testEnable;
    wr(EN_SET, 0, 1'b0, 2'd0, 32'h0000_00F5);
    chkRd("R2", "enable via set reg", EN_SET, 0, 32'h0000_00F5);
    chkRd("R2", "enable via clr reg", EN_CLR, 0, 32'h0000_00F5);
    wr(EN_CLR, 0, 1'b0, 2'd0, 32'h0000_0005);
    chkRd("R2", "enable after clear", EN_SET, 0, 32'h0000_00F0);
    wr(EN_SET, 0, 1'b0, 2'd0, 32'h0);
    chkRd("R2", "zero write no effect", EN_SET, 0, 32'h0000_00F0);
    wr(EN_SET, 1, 1'b0, 2'd0, 32'h8000_0001);
    chkRd("R2", "enable w1", EN_CLR, 1, 32'h8000_0001);
  endtask

  task automatic testActive;
    wr(AC_SET, 1, 1'b0, 2'd0, 32'h0000_FF00);
    wr(AC_CLR, 1, 1'b0, 2'd0, 32'h0000_0F00);
    chkRd("R2", "active via set reg", AC_SET, 1, 32'h0000_F000);
    chkRd("R2", "active via clr reg", AC_CLR, 1, 32'h0000_F000);
    chkRd("R2", "active w0 untouched", AC_SET, 0, 32'h0);
  endtask

  task automatic testPriority;
    logic [31:0] v;
    wr(PRIO, 3, 1'b0, 2'd0, 32'hFFFF_FFFF);
    chkRd("R7", "prio low bits zero", PRIO, 3, 32'hF8F8_F8F8);
    wr(PRIO, 3, 1'b1, 2'd2, 32'hFFFF_FF5A);
    chkRd("R11", "prio byte lane write", PRIO, 3, 32'hF858_F8F8);
    rd(PRIO, 3, 1'b1, 2'd2, v);
    check("R7", "prio byte read lane2", {32'b0, v}, 64'h58);
    rd(PRIO, 3, 1'b1, 2'd1, v);
    check("R11", "prio byte read lane1", {32'b0, v}, 64'hF8);
  endtask

  task automatic testConfig;
    wr(CFG, 0, 1'b0, 2'd0, 32'hFFFF_FFFF);
    chkRd("R9", "private cfg w0 ignored", CFG, 0, 32'h0);
    wr(CFG, 1, 1'b0, 2'd0, 32'hFFFF_FFFF);
    chkRd("R9", "private cfg w1 ignored", CFG, 1, 32'h0);
    wr(CFG, 2, 1'b0, 2'd0, 32'hFFFF_FFFF);
    chkRd("R8", "shared cfg edge, low bits zero", CFG, 2, 32'hAAAA_AAAA);
  endtask

  task automatic testEdge;
    lineLevel[40] = 1'b1;
    step(1);
    check("R6", "edge rise pends", {63'b0, pendingOut[40]}, 64'h1);
    lineLevel[40] = 1'b0;
    step(1);
    check("R6", "edge holds after fall", {63'b0, pendingOut[40]}, 64'h1);
    chkRd("R2", "pending via clr reg", PD_CLR, 1, 32'h0000_0100);
    wr(PD_CLR, 1, 1'b0, 2'd0, 32'h0000_0100);
    check("R4", "edge clear", {63'b0, pendingOut[40]}, 64'h0);
    lineLevel[40] = 1'b1;
    step(1);
    wr(PD_CLR, 1, 1'b0, 2'd0, 32'h0000_0100);
    step(2);
    check("R6", "high line no re-pend", {63'b0, pendingOut[40]}, 64'h0);
    lineLevel[40] = 1'b0;
  endtask

  task automatic testLevel;
    wr(CFG, 2, 1'b0, 2'd0, 32'hFFFF_FFF7);
    chkRd("R8", "irq33 level", CFG, 2, 32'hAAAA_AAA2);
    check("R10", "switch to level, line low", {63'b0, pendingOut[33]}, 64'h0);
    lineLevel[33] = 1'b1;
    step(1);
    check("R5", "level follows high line", {63'b0, pendingOut[33]}, 64'h1);
    lineLevel[33] = 1'b0;
    step(1);
    check("R5", "level follows low line", {63'b0, pendingOut[33]}, 64'h0);
    wr(PD_SET, 1, 1'b0, 2'd0, 32'h0000_0002);
    step(1);
    check("R3", "soft latch holds pending", {63'b0, pendingOut[33]}, 64'h1);
    lineLevel[33] = 1'b1;
    wr(PD_CLR, 1, 1'b0, 2'd0, 32'h0000_0002);
    check("R4", "level clear keeps high line", {63'b0, pendingOut[33]}, 64'h1);
    lineLevel[33] = 1'b0;
    step(1);
    check("R4", "latch cleared by clear", {63'b0, pendingOut[33]}, 64'h0);
  endtask

  task automatic testSwitch;
    wr(PD_SET, 1, 1'b0, 2'd0, 32'h0000_0004);
    check("R3", "edge set pending", {63'b0, pendingOut[34]}, 64'h1);
    wr(CFG, 2, 1'b0, 2'd0, 32'hFFFF_FFD7);
    check("R10", "edge->level drops pend", {63'b0, pendingOut[34]}, 64'h0);
    wr(PD_SET, 1, 1'b0, 2'd0, 32'h0000_0002);
    wr(CFG, 2, 1'b0, 2'd0, 32'hFFFF_FFDF);
    check("R10", "level->edge keeps pend", {63'b0, pendingOut[33]}, 64'h1);
    wr(PD_CLR, 1, 1'b0, 2'd0, 32'h0000_0002);
    check("R4", "edge clear ignores latch", {63'b0, pendingOut[33]}, 64'h0);
    wr(CFG, 2, 1'b0, 2'd0, 32'hFFFF_FFD7);
    check("R10", "stale latch re-pends", {63'b0, pendingOut[33]}, 64'h1);
    wr(PD_CLR, 1, 1'b0, 2'd0, 32'h0000_0002);
    lineLevel[36] = 1'b1;
    step(1);
    wr(PD_CLR, 1, 1'b0, 2'd0, 32'h0000_0010);
    check("R4", "irq36 edge cleared", {63'b0, pendingOut[36]}, 64'h0);
    wr(CFG, 2, 1'b0, 2'd0, 32'hFFFF_FDD7);
    check("R10", "switch to level, line high", {63'b0, pendingOut[36]}, 64'h1);
    lineLevel[36] = 1'b0;
    step(1);
  endtask

  task automatic testRange;
    wr(EN_SET, 2, 1'b0, 2'd0, 32'hFFFF_FFFF);
    chkRd("R11", "oob enable read", EN_SET, 2, 32'h0);
    chkRd("R11", "enable w0 unaffected", EN_SET, 0, 32'h0000_00F0);
    chkRd("R11", "enable w1 unaffected", EN_SET, 1, 32'h8000_0001);
    wr(CFG, 4, 1'b0, 2'd0, 32'hFFFF_FFFF);
    chkRd("R11", "cfg w3 unaffected", CFG, 3, 32'h0);
  endtask

  task automatic testByte;
    logic [31:0] v;
    wr(EN_SET, 0, 1'b1, 2'd1, 32'h0000_0003);
    chkRd("R11", "byte set lane1", EN_SET, 0, 32'h0000_03F0);
    rd(EN_SET, 0, 1'b1, 2'd1, v);
    check("R11", "byte read lane1", {32'b0, v}, 64'h03);
    rd(EN_CLR, 0, 1'b1, 2'd0, v);
    check("R11", "byte read lane0", {32'b0, v}, 64'hF0);
    wr(EN_CLR, 0, 1'b1, 2'd0, 32'h0000_00FF);
    chkRd("R11", "byte clear lane0", EN_SET, 0, 32'h0000_0300);
    wr(EN_SET, 0, 1'b1, 2'd3, 32'hFFFF_FF01);
    chkRd("R11", "byte uses low data only", EN_SET, 0, 32'h0100_0300);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEnable();
    testActive();
    testPriority();
    testConfig();
    testEdge();
    testLevel();
    testSwitch();
    testRange();
    testByte();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule